// File: doc/BRIEF.md
# Two-Thread Fair Back-End Slot Allocator

This block admits micro-operations from two hardware threads into three shared back-end structures: a reorder buffer, a load queue and a store queue. Each thread presents at most one op per cycle, together with a two-bit kind that says whether the op also needs a load-queue slot, a store-queue slot, or neither. In the same cycle, the block picks at most one op and returns a slot index in every structure that op needs. The index encodes the owning thread, because each thread's half of a structure occupies a fixed index range.

Each thread may fill only half of every structure. Inside its half, the thread allocates and frees slots as a circular region, oldest first. When both threads can be served, the grant alternates between them. A thread that cannot be served does not stop the other thread. Retirement returns slots one at a time, per thread and per structure. A flush returns all of one thread's slots in a single cycle.

Top module: `dtra_alloc`

## Requirements
- R1: After reset no op is granted while no request is valid, and the first cycle with both threads requesting grants thread 0.
- R2: At most one thread is granted per cycle (`gnt` is zero or one-hot), only a thread whose `req_valid` bit is set, and the grant and indices appear combinationally in the request cycle.
- R3: When both threads are eligible, the thread granted is the one not granted most recently; a lone eligible thread is always granted.
- R4: Every grant takes a reorder slot. Thread t's slots are t*64 to t*64+63 (default sizes), handed out consecutively and wrapping within that range. A thread holding 64 reorder slots is not granted.
- R5: Kind 2'b01 (load) also takes a load slot. Thread t's load slots are t*24 to t*24+23, handed out consecutively with wrap. A load is not granted while its thread holds 24 load slots.
- R6: Kind 2'b10 (store) also takes a store slot. Thread t's store slots are t*12 to t*12+11, handed out consecutively with wrap. A store is not granted while its thread holds 12 store slots. Kinds 2'b00 and 2'b11 take only a reorder slot.
- R7: An op is granted only if every structure it needs has room, judged on occupancy before this cycle's releases; nothing is taken otherwise. A load or store index output that the granted op does not use, and every index when there is no grant, reads zero.
- R8: A thread that is stalled or not requesting never delays a grant to the other, eligible thread.
- R9: A release pulse for a thread and structure frees that thread's oldest slot there, making room for one more op. A release while the thread holds no slot in that structure has no effect.
- R10: A flush for one thread empties all three of its regions in one cycle, denies that thread a grant in the flush cycle, and restarts its indices at its region base; the other thread's state is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 2 | Per-thread op present (bit t = thread t) |
| req_kind_t0 | input | 2 | Thread 0 op kind: 01 load, 10 store, 00/11 plain |
| req_kind_t1 | input | 2 | Thread 1 op kind, same encoding |
| rel_rob | input | 2 | Per-thread release of oldest reorder slot |
| rel_ld | input | 2 | Per-thread release of oldest load slot |
| rel_st | input | 2 | Per-thread release of oldest store slot |
| flush | input | 2 | Per-thread flush of all held slots |
| gnt | output | 2 | One-hot grant to the selected thread |
| gnt_rob_idx | output | 7 | Reorder slot index of the granted op |
| gnt_ld_idx | output | 6 | Load slot index, zero if unused |
| gnt_st_idx | output | 5 | Store slot index, zero if unused |

## Verification
The hardest situation to reach from the ports is two threads saturated at once in different structures. In that state, one thread is stalled on a full store region while the other is still eligible, and a release and a new request for the full region arrive in the same cycle. Directed phases drive thread 0 with stores and thread 1 with loads until each hits its cap, then apply releases and flushes one at a time. A long random phase then mixes in release pulses at a moderate rate. That rate keeps regions hovering near their caps, so allocation, wrap, release and flush coincide in many combinations.

// File: rtl/dtra_pkg.sv
package dtra_pkg;
    localparam int NUM_THREADS = 2;

    typedef enum logic [1:0] {
        OP_PLAIN     = 2'b00,
        OP_LOAD      = 2'b01,
        OP_STORE     = 2'b10,
        OP_PLAIN_ALT = 2'b11
    } op_kind_e;
endpackage

// File: rtl/dtra_region.sv
module dtra_region #(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_i,
    input  logic                         rel_i,
    input  logic                         flush_i,
    output logic                         full_o,
    output logic [((DEPTH > 1) ? $clog2(DEPTH) : 1)-1:0] tail_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] cnt;
    } reg_state_t;

    reg_state_t st_d, st_q;
    logic       rel_eff;

    always_comb begin
        st_d    = st_q;
        rel_eff = rel_i && (st_q.cnt != '0);
        if (alloc_i) begin
            st_d.tail = (st_q.tail == PW'(DEPTH - 1)) ? '0 : st_q.tail + 1'b1;
        end
        if (rel_eff) begin
            st_d.head = (st_q.head == PW'(DEPTH - 1)) ? '0 : st_q.head + 1'b1;
        end
        st_d.cnt = st_q.cnt + CW'(alloc_i) - CW'(rel_eff);
        if (flush_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o = (st_q.cnt == CW'(DEPTH));
    assign tail_o = st_q.tail;

    AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> (st_q.cnt < CW'(DEPTH)));                              // R7
    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));                                           // R4
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.cnt == '0 && st_q.tail == '0));                  // R10
    AST_PTR_MATCH_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(st_q.tail) - int'(st_q.head) + DEPTH) % DEPTH) ==
        ((st_q.cnt == CW'(DEPTH)) ? 0 : int'(st_q.cnt)));                  // R9
endmodule

// File: rtl/dtra_arb.sv
module dtra_arb (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] elig_i,
    output logic [1:0] gnt_o
);
    typedef struct packed {
        logic prio;
        logic seen;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic [1:0] prev_gnt_q;
    logic [1:0] prev_elig_q;

    always_comb begin
        st_d = st_q;
        if (elig_i == 2'b11) gnt_o = st_q.prio ? 2'b10 : 2'b01;
        else                 gnt_o = elig_i;
        if (gnt_o[0])      st_d.prio = 1'b1;
        else if (gnt_o[1]) st_d.prio = 1'b0;
        st_d.seen = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            prev_gnt_q  <= '0;
            prev_elig_q <= '0;
        end else begin
            st_q        <= st_d;
            prev_gnt_q  <= gnt_o;
            prev_elig_q <= elig_i;
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o));                                                  // R2
    AST_GNT_ONLY_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o & ~elig_i) == 2'b00);                                       // R2
    AST_LONE_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_i != 2'b00) |-> (gnt_o != 2'b00));                           // R8
    AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.seen && elig_i == 2'b11 && prev_elig_q == 2'b11)
        |-> (gnt_o != prev_gnt_q));                                        // R3
endmodule

// File: rtl/dtra_alloc.sv
module dtra_alloc
    import dtra_pkg::*;
#(
    parameter int ROB_ENTRIES = 128,
    parameter int LD_ENTRIES  = 48,
    parameter int ST_ENTRIES  = 24
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [1:0]                     req_valid,
    input  logic [1:0]                     req_kind_t0,
    input  logic [1:0]                     req_kind_t1,
    input  logic [1:0]                     rel_rob,
    input  logic [1:0]                     rel_ld,
    input  logic [1:0]                     rel_st,
    input  logic [1:0]                     flush,
    output logic [1:0]                     gnt,
    output logic [$clog2(ROB_ENTRIES)-1:0] gnt_rob_idx,
    output logic [$clog2(LD_ENTRIES)-1:0]  gnt_ld_idx,
    output logic [$clog2(ST_ENTRIES)-1:0]  gnt_st_idx
);
    localparam int ROB_HALF = ROB_ENTRIES / NUM_THREADS;
    localparam int LD_HALF  = LD_ENTRIES / NUM_THREADS;
    localparam int ST_HALF  = ST_ENTRIES / NUM_THREADS;
    localparam int ROB_IW   = $clog2(ROB_ENTRIES);
    localparam int LD_IW    = $clog2(LD_ENTRIES);
    localparam int ST_IW    = $clog2(ST_ENTRIES);
    localparam int ROB_PW   = (ROB_HALF > 1) ? $clog2(ROB_HALF) : 1;
    localparam int LD_PW    = (LD_HALF > 1) ? $clog2(LD_HALF) : 1;
    localparam int ST_PW    = (ST_HALF > 1) ? $clog2(ST_HALF) : 1;

    op_kind_e    kind     [NUM_THREADS];
    logic [1:0]  need_ld, need_st, fits, elig;
    logic [1:0]  rob_full, ld_full, st_full;
    logic [ROB_PW-1:0] rob_tail [NUM_THREADS];
    logic [LD_PW-1:0]  ld_tail  [NUM_THREADS];
    logic [ST_PW-1:0]  st_tail  [NUM_THREADS];

    assign kind[0] = op_kind_e'(req_kind_t0);
    assign kind[1] = op_kind_e'(req_kind_t1);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign need_ld[t] = (kind[t] == OP_LOAD);
        assign need_st[t] = (kind[t] == OP_STORE);
        assign fits[t]    = !rob_full[t] && !(need_ld[t] && ld_full[t])
                         && !(need_st[t] && st_full[t]);
        assign elig[t]    = req_valid[t] && fits[t] && !flush[t];

        dtra_region #(.DEPTH(ROB_HALF)) u_rob (
            .clk(clk), .rst_n(rst_n), .alloc_i(gnt[t]), .rel_i(rel_rob[t]),
            .flush_i(flush[t]), .full_o(rob_full[t]), .tail_o(rob_tail[t]));
        dtra_region #(.DEPTH(LD_HALF)) u_ld (
            .clk(clk), .rst_n(rst_n), .alloc_i(gnt[t] && need_ld[t]),
            .rel_i(rel_ld[t]), .flush_i(flush[t]), .full_o(ld_full[t]),
            .tail_o(ld_tail[t]));
        dtra_region #(.DEPTH(ST_HALF)) u_st (
            .clk(clk), .rst_n(rst_n), .alloc_i(gnt[t] && need_st[t]),
            .rel_i(rel_st[t]), .flush_i(flush[t]), .full_o(st_full[t]),
            .tail_o(st_tail[t]));
    end

    dtra_arb u_arb (.clk(clk), .rst_n(rst_n), .elig_i(elig), .gnt_o(gnt));

    always_comb begin
        gnt_rob_idx = '0;
        gnt_ld_idx  = '0;
        gnt_st_idx  = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            if (gnt[t]) begin
                gnt_rob_idx = ROB_IW'(t * ROB_HALF) + ROB_IW'(rob_tail[t]);
                if (need_ld[t]) gnt_ld_idx = LD_IW'(t * LD_HALF) + LD_IW'(ld_tail[t]);
                if (need_st[t]) gnt_st_idx = ST_IW'(t * ST_HALF) + ST_IW'(st_tail[t]);
            end
        end
    end

    AST_ROB_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        gnt[1] |-> (gnt_rob_idx >= ROB_IW'(ROB_HALF)));                    // R4
    AST_NO_FLUSH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & flush) == 2'b00);                                           // R10
    AST_PLAIN_NO_LD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != 2'b00 && gnt_ld_idx != '0) |->
        ((gnt[0] && need_ld[0]) || (gnt[1] && need_ld[1])));               // R7
endmodule

// File: tb/dtra_alloc_test.sv
module dtra_alloc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_valid = '0, req_kind_t0 = '0, req_kind_t1 = '0;
    logic [1:0] rel_rob = '0, rel_ld = '0, rel_st = '0, flush = '0;
    logic [1:0] gnt;
    logic [6:0] gnt_rob_idx;
    logic [5:0] gnt_ld_idx;
    logic [4:0] gnt_st_idx;

    int checks = 0;
    int errors = 0;
    int cnt  [2][3];
    int tail [2][3];
    int half [3] = '{64, 24, 12};
    int prio = 0;

    always #2.5 clk = ~clk;

    dtra_alloc uut (.*);

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < 2; t++)
            for (int b = 0; b < 3; b++) begin cnt[t][b] = 0; tail[t][b] = 0; end
        prio = 0;
    endtask

    task automatic step(string tag, logic [1:0] v, logic [1:0] k0, logic [1:0] k1,
                        logic [1:0] rr, logic [1:0] rl, logic [1:0] rs, logic [1:0] fl);
        int need [2][3];
        int el [2];
        int g, er, eld, est;
        logic [1:0] rel [3];
        @(negedge clk);
        req_valid = v; req_kind_t0 = k0; req_kind_t1 = k1;
        rel_rob = rr; rel_ld = rl; rel_st = rs; flush = fl;
        rel[0] = rr; rel[1] = rl; rel[2] = rs;
        #1;
        for (int t = 0; t < 2; t++) begin
            logic [1:0] k;
            int fit;
            k = (t == 0) ? k0 : k1;
            need[t][0] = 1;
            need[t][1] = (k == 2'b01) ? 1 : 0;
            need[t][2] = (k == 2'b10) ? 1 : 0;
            fit = 1;
            for (int b = 0; b < 3; b++)
                if (need[t][b] != 0 && cnt[t][b] >= half[b]) fit = 0;
            el[t] = (v[t] && fit != 0 && !fl[t]) ? 1 : 0;
        end
        if (el[0] != 0 && el[1] != 0) g = prio;
        else if (el[0] != 0)          g = 0;
        else if (el[1] != 0)          g = 1;
        else                          g = -1;
        er = 0; eld = 0; est = 0;
        if (g >= 0) begin
            er  = g * 64 + tail[g][0];
            eld = (need[g][1] != 0) ? g * 24 + tail[g][1] : 0;
            est = (need[g][2] != 0) ? g * 12 + tail[g][2] : 0;
        end
        check(tag, int'(gnt), (g < 0) ? 0 : (1 << g), "gnt");
        check(tag, int'(gnt_rob_idx), er, "rob_idx");
        check(tag, int'(gnt_ld_idx), eld, "ld_idx");
        check(tag, int'(gnt_st_idx), est, "st_idx");
        for (int t = 0; t < 2; t++)
            for (int b = 0; b < 3; b++) begin
                if (fl[t]) begin
                    cnt[t][b] = 0; tail[t][b] = 0;
                end else begin
                    int a, r;
                    a = (g == t && need[t][b] != 0) ? 1 : 0;
                    r = (rel[b][t] && cnt[t][b] > 0) ? 1 : 0;
                    cnt[t][b] += a - r;
                    if (a != 0) tail[t][b] = (tail[t][b] + 1) % half[b];
                end
            end
        if (g >= 0) prio = 1 - g;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (4) @(negedge clk);
        #1;
        check("R1", int'(gnt), 0, "gnt in reset");
        @(negedge clk);
        rst_n = 1'b1;
        step("R1", 2'b00, 2'b00, 2'b00, 0, 0, 0, 0);
        step("R1", 2'b11, 2'b00, 2'b00, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) step("R3", 2'b11, 2'b00, 2'b11, 0, 0, 0, 0);
        step("R2", 2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
        step("R2", 2'b10, 2'b00, 2'b00, 0, 0, 0, 0);
        step("R10", 2'b11, 2'b00, 2'b00, 0, 0, 0, 2'b11);
        // thread 0 stores, thread 1 loads until both caps hit
        for (int i = 0; i < 60; i++) step("R6", 2'b11, 2'b10, 2'b01, 0, 0, 0, 0);
        step("R5", 2'b10, 2'b10, 2'b01, 0, 0, 0, 0);
        step("R7", 2'b01, 2'b00, 2'b01, 0, 0, 0, 0);
        step("R7", 2'b01, 2'b10, 2'b01, 0, 0, 0, 0);
        step("R9", 2'b01, 2'b10, 2'b01, 0, 0, 2'b01, 0);
        step("R9", 2'b01, 2'b10, 2'b01, 0, 0, 0, 0);
        step("R9", 2'b01, 2'b10, 2'b01, 0, 0, 0, 0);
        // thread 1 fills reorder region while thread 0 keeps storing
        for (int i = 0; i < 80; i++) step("R4", 2'b11, 2'b10, 2'b00, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++)  step("R8", 2'b11, 2'b00, 2'b00, 0, 0, 0, 0);
        step("R10", 2'b11, 2'b00, 2'b00, 0, 0, 0, 2'b10);
        for (int i = 0; i < 4; i++)  step("R10", 2'b11, 2'b01, 2'b10, 0, 0, 0, 0);
        // releases on empty regions are ignored
        step("R9", 2'b00, 2'b00, 2'b00, 0, 0, 0, 2'b01);
        for (int i = 0; i < 3; i++)  step("R9", 2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b01, 0);
        for (int i = 0; i < 16; i++) step("R9", 2'b01, 2'b10, 2'b00, 0, 0, 0, 0);
        // random mix
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] fl;
            fl[0] = ($urandom % 80) == 0;
            fl[1] = ($urandom % 80) == 0;
            step("RND", 2'($urandom), 2'($urandom), 2'($urandom),
                 2'($urandom & $urandom), 2'($urandom & $urandom),
                 2'($urandom & $urandom), fl);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule